// File: doc/BRIEF.md
# External and Pin-Change Interrupt Front End

This block sits between the pins of a small microcontroller and its vectored interrupt unit. It watches one dedicated external interrupt pin and a bank of up to 31 general pins, arranged as four pin-change groups of up to eight pins each. For each of its five sources it raises a separate request line. Each line is gated by a per-source enable bit and by the CPU's global interrupt enable.

The external pin has four sense modes: level-low, any change, falling edge and rising edge. A group request is produced when any pin in the group changes and that pin is selected in the group's pin-select register. All pins pass through a two-flop synchronizer. The block looks only at the pin level and has no notion of pin direction, so a pin that the chip drives as an output is still sensed.

Events are latched as sticky pending flags. A flag is cleared when the CPU acknowledges its vector, or when software writes a one to it. In level-low mode no flag is kept, and the request follows the synchronized pin directly. Software reaches the registers through a byte-wide port with a single-cycle write strobe and a combinational read.

Top module: `xirq_ctrl`

## Requirements
- R1: The source-enable register at address 0xD1 has writable bits 7,6,5,4 (enable group 3,2,1,0) and bit 0 (enable external pin). Bits 3..1 always read zero. It reads 0x00 after reset.
- R2: The sense register at 0xD2 keeps bits 1:0 and reads zero above them. The pin-select registers for groups 0..3 sit at 0xD3..0xD6. Group g covers pins 8g..8g+7. Select bits for pins that do not exist (bit 7 of group 3 with 31 pins) read zero. All of these registers reset to zero.
- R3: Request bit i is high only when source i is active, its enable bit is set and globalEn is high. With globalEn low, irqReq is all zero.
- R4: Sense 00 (level-low): irqReq[0] is high while the synchronized external pin is low, without latching a flag (pending bit 0 stays 0). It goes high after the second rising clock edge following the pin's fall.
- R5: Sense 01 sets the external pending flag on either edge of the pin.
- R6: Sense 10 sets the flag on a falling edge only. Sense 11 sets it on a rising edge only.
- R7: A change on a pin whose select bit is set sets that group's pending flag. Changes on deselected pins set nothing.
- R8: The pending register at 0xD7 uses the enable layout: bit 0 is the external flag and bit 4+g is group g. Bits 3..1 read zero. Writing ones clears the chosen flags, and writing zeros leaves them alone.
- R9: A one on ackVec[i] clears pending flag i. ackVec bit 0 is the external pin and bit 1+g is group g.
- R10: A pin change driven between clock edges sets its flag at the third following rising edge. A single-cycle pulse, once its flag is cleared, raises no further request while the pin stays still.
- R11: irqReq bit 0 is the external pin and bit 1+g is pin-change group g.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPin | input | 1 | Dedicated external interrupt pin |
| pinIn | input | PIN_CNT | General pins sensed by the pin-change groups |
| globalEn | input | 1 | CPU global interrupt enable |
| regAddr | input | 8 | Register address |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr, combinational |
| ackVec | input | 5 | Per-source vector acknowledge |
| irqReq | output | 5 | Per-source interrupt request |

## Verification
The assertions assume that the pins are low while reset is held, so the first synchronized sample matches the previous-sample register and no spurious change appears. They also assume that every pin level lasts at least one clock, so the synchronizer sees it. The acknowledge property holds only in cycles where the pin bank has been still long enough for no change to be in flight. The stimulus keeps all pins low through reset and drives pins, writes and acknowledges only on falling clock edges. It holds each pin pattern for several clocks before sampling, and it clears pending flags before every random pattern, so the expected flags depend only on that one transition.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int REG_W     = 8;
  localparam int GRP_CNT   = 4;
  localparam int GRP_W     = 8;
  localparam int SRC_CNT   = GRP_CNT + 1;
  localparam int GRP_IDX_W = $clog2(GRP_CNT);
  localparam int EN_GRP_LSB = 4;
  localparam logic [REG_W-1:0] EN_WR_MASK = 8'hF1;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ENABLE,
    RD_SENSE,
    RD_GROUP,
    RD_PEND
  } rdsel_e;

  typedef struct packed {
    logic                 wrEnable;
    logic                 wrSense;
    logic [GRP_CNT-1:0]   wrGroup;
    logic                 wrPend;
    logic [SRC_CNT-1:0]   ackClr;
    rdsel_e               rdSel;
    logic [GRP_IDX_W-1:0] rdGroup;
  } strobe_t;

  function automatic logic [SRC_CNT-1:0] byteToSrc(input logic [REG_W-1:0] b);
    logic [SRC_CNT-1:0] s;
    s[0] = b[0];
    for (int g = 0; g < GRP_CNT; g++) s[1+g] = b[EN_GRP_LSB+g];
    return s;
  endfunction

  function automatic logic [REG_W-1:0] srcToByte(input logic [SRC_CNT-1:0] s);
    logic [REG_W-1:0] b;
    b = '0;
    b[0] = s[0];
    for (int g = 0; g < GRP_CNT; g++) b[EN_GRP_LSB+g] = s[1+g];
    return b;
  endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/xirq_control.sv
module xirq_control
  import xirq_pkg::*;
#(
  parameter logic [7:0] ENABLE_ADDR = 8'hD1,
  parameter logic [7:0] SENSE_ADDR  = 8'hD2,
  parameter logic [7:0] GROUP_BASE  = 8'hD3,
  parameter logic [7:0] PEND_ADDR   = 8'hD7
) (
  input  logic [7:0]         regAddr,
  input  logic               regWrEn,
  input  logic [SRC_CNT-1:0] ackVec,
  output strobe_t            strb
);
  always_comb begin
    strb         = '0;
    strb.rdSel   = RD_NONE;
    strb.ackClr  = ackVec;
    if (regAddr == ENABLE_ADDR) begin
      strb.rdSel    = RD_ENABLE;
      strb.wrEnable = regWrEn;
    end else if (regAddr == SENSE_ADDR) begin
      strb.rdSel   = RD_SENSE;
      strb.wrSense = regWrEn;
    end else if (regAddr == PEND_ADDR) begin
      strb.rdSel  = RD_PEND;
      strb.wrPend = regWrEn;
    end else begin
      for (int g = 0; g < GRP_CNT; g++) begin
        if (regAddr == GROUP_BASE + 8'(g)) begin
          strb.rdSel      = RD_GROUP;
          strb.rdGroup    = GRP_IDX_W'(g);
          strb.wrGroup[g] = regWrEn;
        end
      end
    end
  end
endmodule

// File: rtl/xirq_datapath.sv
module xirq_datapath
  import xirq_pkg::*;
#(
  parameter int PIN_CNT = 31
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PIN_CNT:0]   pinSync,
  input  logic               globalEn,
  input  logic [REG_W-1:0]   wrData,
  input  strobe_t            strb,
  output logic [REG_W-1:0]   rdData,
  output logic [SRC_CNT-1:0] irqReq
);
  localparam int PAD_W = GRP_CNT * GRP_W;

  function automatic logic [GRP_W-1:0] groupValid(input int g);
    logic [GRP_W-1:0] v;
    for (int b = 0; b < GRP_W; b++) v[b] = (g * GRP_W + b) < PIN_CNT;
    return v;
  endfunction

  logic [REG_W-1:0]   enReg;
  sense_e             senseMode;
  logic [GRP_W-1:0]   grpMask [GRP_CNT];
  logic [PIN_CNT:0]   prevPin;
  logic [SRC_CNT-1:0] pendQ, srcEvt, clrVec, srcEn, srcLive;
  logic [PAD_W-1:0]   padDelta;
  logic               extNow, extOld, extRise, extFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= '0;
      senseMode <= SENSE_LOW;
    end else begin
      if (strb.wrEnable) enReg <= wrData & EN_WR_MASK;
      if (strb.wrSense)  senseMode <= sense_e'(wrData[1:0]);
    end
  end

  for (genvar g = 0; g < GRP_CNT; g++) begin : gGroup
    localparam logic [GRP_W-1:0] VALID = groupValid(g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               grpMask[g] <= '0;
      else if (strb.wrGroup[g]) grpMask[g] <= wrData & VALID;
    end
    assign srcEvt[1+g] = |(padDelta[g*GRP_W +: GRP_W] & grpMask[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPin <= '0;
    else       prevPin <= pinSync;
  end

  always_comb begin
    padDelta = '0;
    padDelta[PIN_CNT-1:0] = pinSync[PIN_CNT:1] ^ prevPin[PIN_CNT:1];
  end

  assign extNow  = pinSync[0];
  assign extOld  = prevPin[0];
  assign extRise = extNow & ~extOld;
  assign extFall = ~extNow & extOld;

  always_comb begin
    unique case (senseMode)
      SENSE_ANY:  srcEvt[0] = extRise | extFall;
      SENSE_FALL: srcEvt[0] = extFall;
      SENSE_RISE: srcEvt[0] = extRise;
      default:    srcEvt[0] = 1'b0;
    endcase
  end

  assign clrVec = strb.ackClr | (strb.wrPend ? byteToSrc(wrData) : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~clrVec) | srcEvt;
  end

  always_comb begin
    srcLive    = pendQ;
    srcLive[0] = (senseMode == SENSE_LOW) ? ~extNow : pendQ[0];
  end

  assign srcEn  = byteToSrc(enReg);
  assign irqReq = srcLive & srcEn & {SRC_CNT{globalEn}};

  always_comb begin
    unique case (strb.rdSel)
      RD_ENABLE: rdData = enReg;
      RD_SENSE:  rdData = {6'b0, senseMode};
      RD_GROUP:  rdData = grpMask[strb.rdGroup];
      RD_PEND:   rdData = srcToByte(pendQ);
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int         PIN_CNT     = 31,
  parameter logic [7:0] ENABLE_ADDR = 8'hD1,
  parameter logic [7:0] SENSE_ADDR  = 8'hD2,
  parameter logic [7:0] GROUP_BASE  = 8'hD3,
  parameter logic [7:0] PEND_ADDR   = 8'hD7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extPin,
  input  logic [PIN_CNT-1:0] pinIn,
  input  logic               globalEn,
  input  logic [7:0]         regAddr,
  input  logic               regWrEn,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  input  logic [4:0]         ackVec,
  output logic [4:0]         irqReq
);
  logic [PIN_CNT:0] pinSync;
  strobe_t          strb;

  xirq_sync #(.W(PIN_CNT + 1)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn({pinIn, extPin}), .syncOut(pinSync)
  );

  xirq_control #(
    .ENABLE_ADDR(ENABLE_ADDR), .SENSE_ADDR(SENSE_ADDR),
    .GROUP_BASE(GROUP_BASE), .PEND_ADDR(PEND_ADDR)
  ) uCtrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .ackVec(ackVec), .strb(strb)
  );

  xirq_datapath #(.PIN_CNT(PIN_CNT)) uData (
    .clk(clk), .rstN(rstN), .pinSync(pinSync), .globalEn(globalEn),
    .wrData(regWrData), .strb(strb), .rdData(regRdData), .irqReq(irqReq)
  );
endmodule

// File: rtl/xirq_checker.sv
module xirq_checker #(
  parameter int         PIN_CNT     = 31,
  parameter logic [7:0] ENABLE_ADDR = 8'hD1,
  parameter logic [7:0] GROUP_BASE  = 8'hD3,
  parameter logic [7:0] PEND_ADDR   = 8'hD7
) (
  input logic               clk,
  input logic               rstN,
  input logic [PIN_CNT-1:0] pinIn,
  input logic               globalEn,
  input logic [7:0]         regAddr,
  input logic [7:0]         regRdData,
  input logic [4:0]         ackVec,
  input logic [4:0]         irqReq
);
  AST_GLOBAL_GATES_ALL: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> irqReq == 5'b0); // R3

  AST_ENABLE_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ENABLE_ADDR) |-> regRdData[3:1] == 3'b0); // R1

  AST_PEND_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == PEND_ADDR) |-> regRdData[3:1] == 3'b0); // R8

  AST_ACK_DROPS_GROUP0: assert property (@(posedge clk) disable iff (!rstN)
    (ackVec[1] && $past(pinIn, 2) == $past(pinIn, 3)) |=> !irqReq[1]); // R9

  if (PIN_CNT < 32) begin : gTopBit
    AST_MISSING_PIN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (regAddr == GROUP_BASE + 8'd3) |-> !regRdData[7]); // R2
  end
endmodule

bind xirq_ctrl xirq_checker #(
  .PIN_CNT(PIN_CNT), .ENABLE_ADDR(ENABLE_ADDR),
  .GROUP_BASE(GROUP_BASE), .PEND_ADDR(PEND_ADDR)
) uChk (
  .clk(clk), .rstN(rstN), .pinIn(pinIn), .globalEn(globalEn),
  .regAddr(regAddr), .regRdData(regRdData), .ackVec(ackVec), .irqReq(irqReq)
);

// File: tb/xirq_ctrl_test.sv
module xirq_ctrl_test;
  localparam int PINS = 31;
  localparam logic [7:0] A_EN = 8'hD1, A_SENSE = 8'hD2, A_GRP = 8'hD3, A_PEND = 8'hD7;

  logic clk = 1'b0, rstN = 1'b0, extPin = 1'b0, globalEn = 1'b0, regWrEn = 1'b0;
  logic [PINS-1:0] pinIn = '0;
  logic [7:0] regAddr = '0, regWrData = '0, regRdData;
  logic [4:0] ackVec = '0, irqReq;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  xirq_ctrl uut (
    .clk(clk), .rstN(rstN), .extPin(extPin), .pinIn(pinIn), .globalEn(globalEn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .ackVec(ackVec), .irqReq(irqReq)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic ack(input logic [4:0] v);
    @(negedge clk); ackVec = v;
    @(posedge clk); #1; ackVec = '0;
  endtask

  function automatic logic [7:0] validMask(input int g);
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[b] = (g * 8 + b) < PINS;
    return v;
  endfunction

  function automatic logic [7:0] expPend(input logic [1:0] mode, input logic eOld, input logic eNew,
                                         input logic [PINS-1:0] pOld, input logic [PINS-1:0] pNew,
                                         input logic [31:0] masks);
    logic [7:0] r;
    logic [31:0] delta;
    r = '0;
    delta = 32'(pOld ^ pNew);
    case (mode)
      2'b01: r[0] = eOld ^ eNew;
      2'b10: r[0] = eOld & ~eNew;
      2'b11: r[0] = ~eOld & eNew;
      default: r[0] = 1'b0;
    endcase
    for (int g = 0; g < 4; g++) r[4+g] = |(delta[g*8 +: 8] & masks[g*8 +: 8]);
    return r;
  endfunction

  function automatic logic [4:0] expReq(input logic [7:0] pend, input logic [7:0] en,
                                        input logic glob, input logic [1:0] mode, input logic eNow);
    logic [4:0] s;
    s[0] = (mode == 2'b00) ? ~eNow : pend[0];
    for (int g = 0; g < 4; g++) s[1+g] = pend[4+g];
    s[0] = s[0] & en[0];
    for (int g = 0; g < 4; g++) s[1+g] = s[1+g] & en[4+g];
    return glob ? s : 5'b0;
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [31:0] masks;
    logic [1:0] mode;
    logic [7:0] en;
    logic [PINS-1:0] pNew;
    logic eNew;
    void'($urandom(32'd20240611));
    ticks(3);
    @(negedge clk) rstN = 1'b1;
    ticks(1);

    // reset state
    rd(A_EN, d);    chk("R1 reset enable", d, 8'h00);
    rd(A_SENSE, d); chk("R2 reset sense", d, 8'h00);
    for (int g = 0; g < 4; g++) begin rd(A_GRP + 8'(g), d); chk("R2 reset group", d, 8'h00); end
    rd(A_PEND, d);  chk("R8 reset pend", d, 8'h00);
    chk("R3 reset irq", irqReq, 5'b0);

    // register widths
    wr(A_EN, 8'hFF);    rd(A_EN, d);    chk("R1 writable bits", d, 8'hF1);
    wr(A_SENSE, 8'hFF); rd(A_SENSE, d); chk("R2 sense width", d, 8'h03);
    wr(A_GRP + 8'd3, 8'hFF); rd(A_GRP + 8'd3, d); chk("R2 group3 top bit", d, 8'h7F);
    wr(A_GRP, 8'hA5);   rd(A_GRP, d);   chk("R2 group0 value", d, 8'hA5);

    // level-low mode, latency and no flag
    wr(A_SENSE, 8'h00); wr(A_EN, 8'h01);
    @(negedge clk) extPin = 1'b1; globalEn = 1'b1;
    ticks(3); chk("R4 high pin no request", irqReq, 5'b0);
    @(negedge clk) extPin = 1'b0;
    ticks(1); chk("R4 one edge after fall", irqReq[0], 1'b0);
    ticks(1); chk("R4 two edges after fall", irqReq[0], 1'b1);
    rd(A_PEND, d); chk("R4 no flag latched", d[0], 1'b0);
    @(negedge clk) globalEn = 1'b0;
    #1 chk("R3 global gate", irqReq, 5'b0);
    @(negedge clk) globalEn = 1'b1; extPin = 1'b1;
    ticks(3); chk("R4 request follows pin", irqReq[0], 1'b0);

    // rising-only mode ignores a fall
    wr(A_SENSE, 8'h03); wr(A_PEND, 8'hFF);
    @(negedge clk) extPin = 1'b0;
    ticks(4); rd(A_PEND, d); chk("R6 rise mode ignores fall", d[0], 1'b0);
    @(negedge clk) extPin = 1'b1;
    ticks(4); chk("R6 rise mode request", irqReq[0], 1'b1);
    ack(5'b00001); chk("R9 ack clears external", irqReq[0], 1'b0);

    // pin-change latency and single pulse
    wr(A_EN, 8'hF0); wr(A_GRP, 8'h08); wr(A_PEND, 8'hFF);
    @(negedge clk) pinIn[3] = 1'b1;
    ticks(2); chk("R10 no flag before third edge", irqReq, 5'b0);
    ticks(1); chk("R10 flag at third edge R11", irqReq, 5'b00010);
    @(negedge clk) pinIn[3] = 1'b0;
    ticks(4); wr(A_PEND, 8'h10);
    ticks(6); chk("R10 pulse raises no more", irqReq, 5'b0);

    // deselected pin, group 3 top pin, group 2 mapping
    wr(A_GRP, 8'h00);
    @(negedge clk) pinIn[3] = 1'b1;
    ticks(4); rd(A_PEND, d); chk("R7 deselected pin ignored", d, 8'h00);
    wr(A_GRP + 8'd3, 8'h40);
    @(negedge clk) pinIn[30] = 1'b1;
    ticks(4); chk("R11 group3 line", irqReq, 5'b10000);
    wr(A_GRP + 8'd2, 8'h01);
    @(negedge clk) pinIn[16] = 1'b1;
    ticks(4); chk("R11 group2 line", irqReq, 5'b11000);
    ack(5'b01000); chk("R9 ack clears group2 only", irqReq, 5'b10000);
    wr(A_PEND, 8'h80); rd(A_PEND, d); chk("R8 write one clears", d, 8'h00);

    // random patterns
    for (int it = 0; it < 150; it++) begin
      masks = $urandom;
      masks[31] = 1'b0;
      mode = 2'($urandom);
      en = 8'($urandom) & 8'hF1;
      for (int g = 0; g < 4; g++) wr(A_GRP + 8'(g), masks[g*8 +: 8]);
      wr(A_SENSE, {6'b0, mode}); wr(A_EN, en);
      wr(A_PEND, 8'hFF);
      @(negedge clk);
      globalEn = ($urandom % 4) != 0;
      pNew = pinIn ^ PINS'($urandom & $urandom & $urandom);
      eNew = ($urandom % 2) == 1;
      d = expPend(mode, extPin, eNew, pinIn, pNew, masks);
      pinIn = pNew; extPin = eNew;
      ticks(4);
      chk("R3 R5 R7 random request", irqReq, expReq(d, en, globalEn, mode, eNew));
      begin
        logic [7:0] got;
        rd(A_PEND, got);
        chk("R5 R6 R7 random pend", got, d);
      end
    end
    if (validMask(3) != 8'h7F) chk("R2 model", validMask(3), 8'h7F);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule